// File: doc/BRIEF.md
# Edge-Triggered Timer Capture Channel

This block is a single input-capture channel that sits beside a free-running 16-bit timer. A level on an external capture pin is brought into the clock domain through a two-flop synchronizer. When the selected edge condition is met, the timer value at that moment is frozen into a 16-bit capture word. The host reads that word through a small byte-wide register bus, as a low byte and a high byte. A captured word that the host has not yet fully read is protected: later edges do not replace it, and instead set a hidden overflow bit.

The hidden bit is moved into a host-visible overflow status bit only when the word has been fully read, meaning both bytes in either order. The host therefore sees, right after a read, whether events were lost while that word was waiting. Each accepted capture raises an interrupt flag, and the flag drives the interrupt output only when the enable bit is set. A mode bit turns the two data addresses over to a timer period register. While that mode is on, capture is suspended.

Register map (`bus_addr`): 0 is control/status, 1 is the data low byte, 2 is the data high byte, and 3 reads as zero. Control bits: [1:0] edge select, [2] interrupt enable, [3] period mode, [4] overflow status (read-only), [5] interrupt flag, [7:6] read as zero.

Top module: `capture_channel`

## Requirements
- R1: When a qualifying edge occurs and no unread word is held, the capture word takes the `timer_val` present at the third clock edge that samples the new pin level.
- R2: While an unread word is held, a further qualifying edge leaves the word unchanged and sets the hidden overflow bit.
- R3: The word counts as read only once both address 1 and address 2 have been read since the last completion, in either order; repeated reads of one byte do not complete it.
- R4: On completion, the overflow status (control bit 4) takes the hidden bit's value, and the hidden bit clears, so a completion with no lost event reports 0.
- R5: Edge select (control [1:0]): 00 captures on every falling edge, 01 on every rising edge, 10 on every 4th rising edge, and 11 on every 16th rising edge. Any write to address 0 restarts the rising-edge count.
- R6: Every accepted capture sets the flag (control bit 5). `irq` is the flag ANDed with the enable (bit 2). Writing address 0 loads the flag from `bus_wdata[5]`, and a capture in the same cycle wins.
- R7: After reset, control/status reads 0x00 and `irq` is 0.
- R8: With period mode (control bit 3) set, addresses 1 and 2 write and read the period register shown on `period_out`. Edges cause no capture and no flag, and the capture word is kept for when the mode is left.
- R9: If the completing byte read and a qualifying edge fall in the same cycle, the read completes first, and the edge is then accepted as a new capture without raising overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| timer_val | input | 16 | Free-running timer value |
| cap_pin | input | 1 | External capture pin (asynchronous) |
| bus_addr | input | 2 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (reads of data bytes are tracked) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, zero when `bus_rd` is low |
| period_out | output | 16 | Timer period register |
| irq | output | 1 | Interrupt request (flag AND enable) |

## Verification
Single isolated pin pulses with the timer held at a known value establish basic latching and separate the rising and falling selections. Back-to-back pulses with no read in between, followed by reads in low-high and high-low order, and a repeated read of a single byte, separate correct completion tracking from naive per-byte clearing. Trains of 3, 4, 15 and 16 pulses, with a control write in mid-train, tell the prescale divisors apart and show whether the count restarts. A read timed to land exactly on the capture cycle distinguishes completion-first ordering from blocking the new event.

// File: rtl/capture_channel.sv
module capture_channel #(
  parameter int PS_LO = 4,
  parameter int PS_HI = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] timer_val,
  input  logic        cap_pin,
  input  logic [1:0]  bus_addr,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [7:0]  bus_wdata,
  output logic [7:0]  bus_rdata,
  output logic [15:0] period_out,
  output logic        irq
);
  localparam int PW = $clog2(PS_HI);

  logic [1:0]    sel_q;
  logic          ie_q, pmode_q, flag_q, slave_q, master_q, full_q, lo_seen, hi_seen;
  logic [2:0]    sync_q;
  logic [PW-1:0] pre_q;
  logic [15:0]   cap_q, per_q;
  logic          qual;

  wire rise    = sync_q[1] & ~sync_q[2];
  wire fall    = ~sync_q[1] & sync_q[2];
  wire ctl_wr  = bus_wr && bus_addr == 2'd0;
  wire lo_rd   = bus_rd && bus_addr == 2'd1 && !pmode_q;
  wire hi_rd   = bus_rd && bus_addr == 2'd2 && !pmode_q;
  wire [PW-1:0] pre_lim = (sel_q == 2'd2) ? PW'(PS_LO - 1) : PW'(PS_HI - 1);
  wire pre_hit = pre_q == pre_lim;

  always_comb begin
    case (sel_q)
      2'd0:    qual = fall;
      2'd1:    qual = rise;
      default: qual = rise && pre_hit;
    endcase
  end

  wire edge_ok = qual && !pmode_q;
  wire done    = (lo_seen | lo_rd) & (hi_seen | hi_rd);
  wire take    = edge_ok && (!full_q || done);
  wire blocked = edge_ok && full_q && !done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q   <= '0;
      pre_q    <= '0;
      sel_q    <= '0;
      ie_q     <= 1'b0;
      pmode_q  <= 1'b0;
      flag_q   <= 1'b0;
      slave_q  <= 1'b0;
      master_q <= 1'b0;
      full_q   <= 1'b0;
      lo_seen  <= 1'b0;
      hi_seen  <= 1'b0;
    end else begin
      sync_q <= {sync_q[1], sync_q[0], cap_pin};
      if (ctl_wr)
        pre_q <= '0;
      else if (sel_q[1] && rise)
        pre_q <= pre_hit ? '0 : pre_q + 1'b1;
      if (ctl_wr)
        {pmode_q, ie_q, sel_q} <= bus_wdata[3:0];
      if (take)
        flag_q <= 1'b1;
      else if (ctl_wr)
        flag_q <= bus_wdata[5];
      if (done) begin
        slave_q  <= master_q;
        master_q <= 1'b0;
        full_q   <= 1'b0;
        lo_seen  <= 1'b0;
        hi_seen  <= 1'b0;
      end else begin
        lo_seen <= lo_seen | lo_rd;
        hi_seen <= hi_seen | hi_rd;
      end
      if (take)    full_q   <= 1'b1;
      if (blocked) master_q <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (take) cap_q <= timer_val;
    if (bus_wr && pmode_q && bus_addr == 2'd1) per_q[7:0]  <= bus_wdata;
    if (bus_wr && pmode_q && bus_addr == 2'd2) per_q[15:8] <= bus_wdata;
  end

  always_comb begin
    bus_rdata = 8'h00;
    if (bus_rd)
      case (bus_addr)
        2'd0: bus_rdata = {2'b00, flag_q, slave_q, pmode_q, ie_q, sel_q};
        2'd1: bus_rdata = pmode_q ? per_q[7:0]  : cap_q[7:0];
        2'd2: bus_rdata = pmode_q ? per_q[15:8] : cap_q[15:8];
        default: bus_rdata = 8'h00;
      endcase
  end

  assign period_out = per_q;
  assign irq        = flag_q & ie_q;

  a_r1_capture_value: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (cap_q == $past(timer_val)) && full_q);
  a_r2_keep_unread: assert property (@(posedge clk) disable iff (!rst_n)
    (full_q && !done) |=> cap_q == $past(cap_q));
  a_r2_overflow_set: assert property (@(posedge clk) disable iff (!rst_n)
    blocked |=> master_q);
  a_r4_transfer: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (slave_q == $past(master_q)) && !master_q);
  a_r6_flag_on_capture: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> flag_q);
  a_r9_accept_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    (done && edge_ok) |=> full_q && !master_q);
  a_r8_no_capture_in_period: assert property (@(posedge clk) disable iff (!rst_n)
    pmode_q |=> cap_q == $past(cap_q));
endmodule

// File: tb/capture_channel_test.sv
`timescale 1ns/1ps
module capture_channel_test;
  logic        clk = 0, rst_n = 0;
  logic [15:0] timer_val = 0;
  logic        cap_pin = 0;
  logic [1:0]  bus_addr = 0;
  logic        bus_wr = 0, bus_rd = 0;
  logic [7:0]  bus_wdata = 0;
  logic [7:0]  bus_rdata;
  logic [15:0] period_out;
  logic        irq;

  int n_chk = 0, n_fail = 0;
  bit per_known = 0;

  capture_channel uut (.clk(clk), .rst_n(rst_n), .timer_val(timer_val), .cap_pin(cap_pin),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .period_out(period_out), .irq(irq));

  always #4 clk = ~clk;

  int m_sel, m_ie, m_pm, m_flag, m_slave, m_master, m_full, m_lo, m_hi, m_pre;
  int m_cap = 0, m_per = 0;
  bit pin_q[$] = '{0, 0, 0};

  always @(posedge clk) begin
    if (!rst_n) begin
      m_sel = 0; m_ie = 0; m_pm = 0; m_flag = 0; m_slave = 0; m_master = 0;
      m_full = 0; m_lo = 0; m_hi = 0; m_pre = 0;
      pin_q = '{0, 0, 0};
    end else begin
      bit r, f, q, ctl, lor, hir, dn, tk;
      int lim;
      r   = pin_q[1] && !pin_q[2];
      f   = !pin_q[1] && pin_q[2];
      lim = (m_sel == 2) ? 4 : 16;
      if (m_sel == 0) q = f;
      else if (m_sel == 1) q = r;
      else q = r && (m_pre == lim - 1);
      q   = q && (m_pm == 0);
      ctl = bus_wr && bus_addr == 0;
      lor = bus_rd && bus_addr == 1 && m_pm == 0;
      hir = bus_rd && bus_addr == 2 && m_pm == 0;
      dn  = (m_lo || lor) && (hi_or(m_hi, hir));
      tk  = q && (m_full == 0 || dn);
      if (ctl) m_pre = 0;
      else if (m_sel >= 2 && r) m_pre = (m_pre == lim - 1) ? 0 : m_pre + 1;
      if (m_pm == 1 && bus_wr && bus_addr == 1) m_per = (m_per & 'hFF00) | bus_wdata;
      if (m_pm == 1 && bus_wr && bus_addr == 2) m_per = (m_per & 'h00FF) | (bus_wdata << 8);
      if (dn) begin
        m_slave = m_master; m_master = 0; m_full = 0; m_lo = 0; m_hi = 0;
      end else begin
        if (lor) m_lo = 1;
        if (hir) m_hi = 1;
      end
      if (tk) begin m_full = 1; m_cap = timer_val; m_flag = 1; end
      else begin
        if (q) m_master = 1;
        if (ctl) m_flag = bus_wdata[5];
      end
      if (ctl) begin
        m_sel = bus_wdata[1:0]; m_ie = bus_wdata[2]; m_pm = bus_wdata[3];
      end
      pin_q.push_front(cap_pin);
      void'(pin_q.pop_back());
    end
  end

  function automatic bit hi_or(int a, bit b);
    return (a != 0) || b;
  endfunction

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      int e;
      e = 0;
      if (bus_rd) begin
        case (bus_addr)
          0: e = (m_flag << 5) | (m_slave << 4) | (m_pm << 3) | (m_ie << 2) | m_sel;
          1: e = m_pm ? (m_per & 'hFF) : (m_cap & 'hFF);
          2: e = m_pm ? (m_per >> 8) : (m_cap >> 8);
          default: e = 0;
        endcase
      end
      chk(bus_addr == 0 ? "R4 model ctrl read" : "R1 model data read", bus_rdata, e);
      chk("R6 model irq", irq, m_flag & m_ie);
      if (per_known) chk("R8 model period", period_out, m_per);
    end
  end

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(int a, int d);
    bus_addr = a[1:0]; bus_wdata = d[7:0]; bus_wr = 1;
    tick(1);
    bus_wr = 0;
  endtask

  task automatic rd(int a, output int d);
    bus_addr = a[1:0]; bus_rd = 1;
    @(negedge clk);
    d = bus_rdata;
    tick(1);
    bus_rd = 0;
  endtask

  task automatic pulse(int n);
    for (int i = 0; i < n; i++) begin
      cap_pin = 1; tick(6);
      cap_pin = 0; tick(6);
    end
  endtask

  task automatic drain();
    int d;
    rd(1, d); rd(2, d);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #1600000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    int v;
    tick(3);
    rst_n = 1;
    tick(2);
    rd(0, v); chk("R7 ctrl after reset", v, 0);
    chk("R7 irq after reset", irq, 0);

    wr(0, 'h05);
    timer_val = 'h1234; pulse(1);
    chk("R6 irq after capture", irq, 1);
    timer_val = 'h5678; pulse(1);
    rd(1, v); chk("R2 low byte kept", v, 'h34);
    rd(1, v);
    rd(0, v); chk("R3 one byte twice not complete", v & 'h10, 0);
    rd(2, v); chk("R2 high byte kept", v, 'h12);
    rd(0, v); chk("R4 overflow visible", v & 'h10, 'h10);
    wr(0, 'h05); chk("R6 flag cleared", irq, 0);
    timer_val = 'h0BEE; pulse(1);
    rd(2, v); chk("R3 high first", v, 'h0B);
    rd(1, v); chk("R3 low second", v, 'hEE);
    rd(0, v); chk("R4 overflow cleared", v & 'h10, 0);

    wr(0, 'h01);
    timer_val = 'h4242; pulse(1);
    chk("R6 irq gated", irq, 0);
    rd(0, v); chk("R6 flag set while gated", v & 'h20, 'h20);
    drain();

    wr(0, 'h04);
    timer_val = 'h1111; cap_pin = 1; tick(6);
    chk("R5 falling ignores rise", irq, 0);
    timer_val = 'h2222; cap_pin = 0; tick(6);
    chk("R5 falling captures", irq, 1);
    rd(1, v); chk("R5 falling value", v, 'h22);
    rd(2, v);

    wr(0, 'h06);
    pulse(3); chk("R5 div4 after 3", irq, 0);
    timer_val = 'h3344; pulse(1); chk("R5 div4 after 4", irq, 1);
    rd(1, v); chk("R5 div4 value", v, 'h44);
    rd(2, v);
    wr(0, 'h06);
    pulse(2);
    wr(0, 'h06);
    pulse(3); chk("R5 count restarts on write", irq, 0);
    pulse(1); chk("R5 restarted count reaches 4", irq, 1);
    drain();

    wr(0, 'h07);
    pulse(15); chk("R5 div16 after 15", irq, 0);
    timer_val = 'h7777; pulse(1); chk("R5 div16 after 16", irq, 1);
    drain();

    wr(0, 'h08);
    wr(1, 'hCD); wr(2, 'hAB);
    per_known = 1;
    chk("R8 period out", period_out, 'hABCD);
    rd(1, v); chk("R8 period low read", v, 'hCD);
    timer_val = 'h9999; pulse(1);
    rd(0, v); chk("R8 no flag in period mode", v & 'h20, 0);
    wr(0, 'h05);
    rd(1, v); chk("R8 capture word kept", v, 'h77);
    rd(2, v); chk("R8 capture word kept high", v, 'h77);

    timer_val = 'hAAAA; pulse(1);
    timer_val = 'hBBBB; pulse(1);
    rd(1, v);
    timer_val = 'hCCCC; cap_pin = 1;
    tick(1); tick(1);
    rd(2, v); chk("R9 completing read sees old word", v, 'hAA);
    tick(6); cap_pin = 0; tick(6);
    rd(0, v); chk("R9 overflow transferred", v & 'h10, 'h10);
    rd(1, v); chk("R9 new capture low", v, 'hCC);
    rd(2, v); chk("R9 new capture high", v, 'hCC);
    rd(0, v); chk("R9 no overflow from edge", v & 'h10, 0);

    tick(4);
    summary();
  end
endmodule